// File: doc/BRIEF.md
# Multi-Issue Register Scoreboard

This block tracks which architectural registers still have a write in flight, so that a dispatch stage issuing up to `N` instructions per cycle never sends out an instruction that reads one of them too early. Each dispatch slot presents its source registers, its destination register and a write-enable. The block answers in the same cycle with a per-slot stall. A slot that does not stall is treated as issued, and its destination is marked pending at the next clock edge. Writeback ports clear pending marks as results land.

Hazards are found in two places. The first is against the pending state left by earlier cycles. The second is between slots of the current group: a slot whose source matches the destination of an earlier valid slot in the same group must wait. Once a slot stalls, every later slot stalls as well, so issue stays in program order. Each register keeps a small pending counter rather than a single bit, so overlapping writes to one register need the matching number of removals. The parameter `BYPASS` sets whether a writeback removal in a cycle is seen by that cycle's lookups (bypassing register file) or only from the next cycle on.

Top module: `mi_scoreboard`

## Requirements
- R1: After reset no register is pending, so a valid slot 0 never stalls in the first cycle after reset, whatever its sources.
- R2: Once a slot issues with its write-enable set and destination d (d nonzero), a later valid slot reading d stalls until enough removals of d have arrived.
- R3: A valid slot k stalls when one of its nonzero sources equals the destination of a valid, write-enabled earlier slot j (j < k) of the same group.
- R4: When slot k stalls, every slot above k stalls in the same cycle; an invalid slot or a slot without a hazard below k does not stall slot k.
- R5: Register 0 is never pending: a source of 0 never causes a stall, and writes or removals naming register 0 have no effect.
- R6: Only issued slots insert: a slot that is invalid or stalled leaves its destination not pending.
- R7: With `BYPASS`=1 a removal in the current cycle clears the hazard in that same cycle; with `BYPASS`=0 the lookup sees only the state from before that cycle's removals.
- R8: Each register holds a pending count that rises by one per issued write and falls by one per removal, saturating at 3 and never going below 0; the register is pending while the count is nonzero.
- R9: Several writeback ports may remove in one cycle, including two removals of the same register, and each counts once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | N | Slot holds an instruction this cycle; bit 0 is the oldest slot |
| disp_src | input | N*NSRC*RW | Source registers; slot k source s at bits [(k*NSRC+s)*RW +: RW] |
| disp_dst | input | N*RW | Destination register; slot k at bits [k*RW +: RW] |
| disp_dwe | input | N | Slot writes its destination |
| wb_valid | input | NWB | Writeback port removes a pending write |
| wb_reg | input | NWB*RW | Register removed; port p at bits [p*RW +: RW] |
| stall | output | N | Slot may not issue this cycle |

## Verification
The hardest state to reach from the ports is a register with a count above one whose last removals arrive together with a read of that register, because only then do saturation, multi-port removal and the removal-versus-lookup order all matter at once. The stimulus drives two-slot groups that both write the same register for several cycles to push the count to its limit. It then removes through both writeback ports at once and finally through one port while slot 0 reads that register. Two instances, one per `BYPASS` setting, see the same inputs, so the one-cycle difference in when the stall clears shows up directly.

// File: rtl/mi_scoreboard.sv
module mi_scoreboard #(
  parameter int N      = 2,
  parameter int NSRC   = 2,
  parameter int NWB    = 2,
  parameter int NREG   = 32,
  parameter bit BYPASS = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                disp_valid,
  input  logic [N*NSRC*$clog2(NREG)-1:0] disp_src,
  input  logic [N*$clog2(NREG)-1:0]   disp_dst,
  input  logic [N-1:0]                disp_dwe,
  input  logic [NWB-1:0]              wb_valid,
  input  logic [NWB*$clog2(NREG)-1:0] wb_reg,
  output logic [N-1:0]                stall
);
  localparam int RW = $clog2(NREG);
  localparam int CW = $clog2(N + NWB + 4) + 1;

  logic [1:0]      cnt [NREG];
  logic [CW-1:0]   inc [NREG];
  logic [CW-1:0]   dec [NREG];
  logic [NREG-1:0] busy;
  logic [N-1:0]    hazard;
  logic [N-1:0]    issue;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      dec[r] = '0;
      for (int p = 0; p < NWB; p++)
        if (wb_valid[p] && wb_reg[p*RW +: RW] == RW'(r))
          dec[r] = dec[r] + CW'(1);
      if (r == 0)
        busy[r] = 1'b0;
      else if (BYPASS)
        busy[r] = CW'(cnt[r]) > dec[r];
      else
        busy[r] = cnt[r] != 2'd0;
    end
  end

  always_comb begin
    logic          hit;
    logic [RW-1:0] a;
    for (int k = 0; k < N; k++) begin
      hit = 1'b0;
      for (int s = 0; s < NSRC; s++) begin
        a = disp_src[(k*NSRC+s)*RW +: RW];
        if (a != '0) begin
          if (busy[a]) hit = 1'b1;
          for (int j = 0; j < k; j++)
            if (disp_valid[j] && disp_dwe[j] && disp_dst[j*RW +: RW] == a)
              hit = 1'b1;
        end
      end
      hazard[k] = disp_valid[k] && hit;
    end
  end

  always_comb begin
    logic blk;
    blk = 1'b0;
    for (int k = 0; k < N; k++) begin
      blk      = blk | hazard[k];
      stall[k] = blk;
    end
  end

  assign issue = disp_valid & ~stall;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      inc[r] = '0;
      for (int k = 0; k < N; k++)
        if (issue[k] && disp_dwe[k] && disp_dst[k*RW +: RW] == RW'(r))
          inc[r] = inc[r] + CW'(1);
    end
  end

  function automatic logic [1:0] step(input logic [1:0] c,
                                      input logic [CW-1:0] up,
                                      input logic [CW-1:0] dn);
    logic [CW-1:0] t;
    t = CW'(c) + up;
    if (t <= dn)            return 2'd0;
    else if (t - dn > CW'(3)) return 2'd3;
    else                    return 2'(t - dn);
  endfunction

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (!rst_n || r == 0) cnt[r] <= 2'd0;
      else                  cnt[r] <= step(cnt[r], inc[r], dec[r]);
    end
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int N      = 2,
  parameter int NSRC   = 2,
  parameter int NWB    = 2,
  parameter int NREG   = 32,
  parameter bit BYPASS = 1'b1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N-1:0]                disp_valid,
  input logic [N*NSRC*$clog2(NREG)-1:0] disp_src,
  input logic [N*$clog2(NREG)-1:0]   disp_dst,
  input logic [N-1:0]                disp_dwe,
  input logic [NWB-1:0]              wb_valid,
  input logic [NWB*$clog2(NREG)-1:0] wb_reg,
  input logic [N-1:0]                stall
);
  localparam int RW = $clog2(NREG);

  wire [RW-1:0] s00  = disp_src[RW-1:0];
  wire [RW-1:0] d0   = disp_dst[RW-1:0];
  wire [RW-1:0] w0   = wb_reg[RW-1:0];
  wire          src0_zero = disp_src[NSRC*RW-1:0] == '0;
  wire          wr0  = disp_valid[0] && !stall[0] && disp_dwe[0] && d0 != '0;
  wire          chk_unused = ^{disp_src, disp_dst, disp_dwe, wb_reg, wb_valid};

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && disp_valid[0]) |-> !stall[0]);

  a_r5_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid[0] && src0_zero) |-> !stall[0]);

  a_r2_pending_read: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr0) && $past(wb_valid) == '0 && wb_valid == '0 &&
     disp_valid[0] && s00 == $past(d0)) |-> stall[0]);

  a_r7_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (!BYPASS && $past(rst_n) && $past(wr0) && $past(wb_valid) == '0 &&
     wb_valid[0] && w0 == $past(d0) && disp_valid[0] && s00 == $past(d0))
    |-> stall[0]);

  generate
    if (N >= 2) begin : g_pair
      wire [RW-1:0] s10 = disp_src[NSRC*RW +: RW];

      a_r3_intra_group: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid[0] && disp_dwe[0] && d0 != '0 && disp_valid[1] && s10 == d0)
        |-> stall[1]);

      a_r4_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        stall[0] |-> stall[1]);
    end
  endgenerate
endmodule

bind mi_scoreboard sb_checker #(
  .N(N), .NSRC(NSRC), .NWB(NWB), .NREG(NREG), .BYPASS(BYPASS)
) u_chk (.*);

// File: tb/tb_mi_scoreboard.sv
module tb_mi_scoreboard;
  localparam int N = 2, NSRC = 2, NWB = 2, NREG = 32, RW = 5;

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] v;
    logic [4:0] a0, b0, d0; logic w0;
    logic [4:0] a1, b1, d1; logic w1;
    logic [1:0] wv;
    logic [4:0] wa0, wa1;
    logic [1:0] es, en;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1, 2'b11,  5, 6, 7,1,  8, 9,10,1, 2'b00,  0, 0, 2'b00, 2'b00}, // R1
    '{2, 2'b11,  7, 0, 0,0,  1, 2,11,1, 2'b00,  0, 0, 2'b11, 2'b11}, // R2 R4
    '{6, 2'b01, 11, 0, 0,0,  0, 0, 0,0, 2'b00,  0, 0, 2'b00, 2'b00}, // R6
    '{3, 2'b11,  1, 2,12,1, 12, 3,13,1, 2'b00,  0, 0, 2'b10, 2'b10}, // R3
    '{6, 2'b11, 13, 0, 0,0, 12, 0, 0,0, 2'b00,  0, 0, 2'b10, 2'b10}, // R6
    '{7, 2'b01,  7, 0, 0,0,  0, 0, 0,0, 2'b01,  7, 0, 2'b00, 2'b11}, // R7
    '{2, 2'b01,  7, 0, 0,0,  0, 0, 0,0, 2'b00,  0, 0, 2'b00, 2'b00}, // R2
    '{9, 2'b11, 10, 0, 0,0, 12, 0, 0,0, 2'b11, 10,12, 2'b00, 2'b11}, // R9
    '{8, 2'b11,  0, 0,20,1,  0, 0,20,1, 2'b00,  0, 0, 2'b00, 2'b00}, // R8
    '{8, 2'b01, 20, 0, 0,0,  0, 0, 0,0, 2'b01, 20, 0, 2'b11, 2'b11}, // R8
    '{8, 2'b01, 20, 0, 0,0,  0, 0, 0,0, 2'b01, 20, 0, 2'b00, 2'b11}, // R8
    '{8, 2'b11,  0, 0,21,1,  0, 0,21,1, 2'b00,  0, 0, 2'b00, 2'b00}, // R8
    '{8, 2'b11,  0, 0,21,1,  0, 0,21,1, 2'b00,  0, 0, 2'b00, 2'b00}, // R8
    '{9, 2'b01, 21, 0, 0,0,  0, 0, 0,0, 2'b11, 21,21, 2'b11, 2'b11}, // R9
    '{8, 2'b01, 21, 0, 0,0,  0, 0, 0,0, 2'b01, 21, 0, 2'b00, 2'b11}, // R8
    '{8, 2'b01, 21, 0, 0,0,  0, 0, 0,0, 2'b00,  0, 0, 2'b00, 2'b00}, // R8
    '{5, 2'b11,  0, 0, 0,1,  0, 0, 0,0, 2'b01,  0, 0, 2'b00, 2'b00}, // R5
    '{5, 2'b01,  0, 0, 0,0,  0, 0, 0,0, 2'b00,  0, 0, 2'b00, 2'b00}, // R5
    '{6, 2'b10,  0, 0, 5,1,  5, 0, 0,0, 2'b00,  0, 0, 2'b00, 2'b00}, // R6 R4
    '{6, 2'b01,  5, 0, 0,0,  0, 0, 0,0, 2'b00,  0, 0, 2'b00, 2'b00}, // R6
    '{8, 2'b00,  0, 0, 0,0,  0, 0, 0,0, 2'b01, 30, 0, 2'b00, 2'b00}, // R8
    '{8, 2'b01,  0, 0,30,1,  0, 0, 0,0, 2'b00,  0, 0, 2'b00, 2'b00}, // R8
    '{2, 2'b01, 30, 0, 0,0,  0, 0, 0,0, 2'b00,  0, 0, 2'b11, 2'b11}, // R2
    '{4, 2'b11,  1, 0, 0,0, 30, 0, 0,0, 2'b00,  0, 0, 2'b10, 2'b10}  // R4
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]           disp_valid = '0;
  logic [N*NSRC*RW-1:0]   disp_src = '0;
  logic [N*RW-1:0]        disp_dst = '0;
  logic [N-1:0]           disp_dwe = '0;
  logic [NWB-1:0]         wb_valid = '0;
  logic [NWB*RW-1:0]      wb_reg = '0;
  logic [N-1:0]           stall, stall_nb;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mi_scoreboard #(.N(N), .NSRC(NSRC), .NWB(NWB), .NREG(NREG), .BYPASS(1'b1)) dut (
    .clk, .rst_n, .disp_valid, .disp_src, .disp_dst, .disp_dwe,
    .wb_valid, .wb_reg, .stall(stall));

  mi_scoreboard #(.N(N), .NSRC(NSRC), .NWB(NWB), .NREG(NREG), .BYPASS(1'b0)) dut_nb (
    .clk, .rst_n, .disp_valid, .disp_src, .disp_dst, .disp_dwe,
    .wb_valid, .wb_reg, .stall(stall_nb));

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: stall actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    @(negedge clk);
    disp_valid = t.v;
    disp_src   = {t.b1, t.a1, t.b0, t.a0};
    disp_dst   = {t.d1, t.d0};
    disp_dwe   = {t.w1, t.w0};
    wb_valid   = t.wv;
    wb_reg     = {t.wa1, t.wa0};
    #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run actual hung, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    vec_t t;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: first cycle after reset, nothing pending
    t = '{1, 2'b11, 7, 10, 0,0, 20, 21, 0,0, 2'b00, 0, 0, 2'b00, 2'b00};
    drive(t);
    check("R1 reset state (bypass)", stall, 2'b00);
    check("R1 reset state (no bypass)", stall_nb, 2'b00);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      check($sformatf("R%0d vector %0d (bypass)", TBL[i].req, i), stall, TBL[i].es);
      check($sformatf("R%0d vector %0d (no bypass)", TBL[i].req, i), stall_nb, TBL[i].en);
    end

    // R2: register 30 still pending before a mid-run reset
    t = '{2, 2'b01, 30, 0, 0,0, 0, 0, 0,0, 2'b00, 0, 0, 2'b00, 2'b00};
    drive(t);
    check("R2 pending before reset", stall, 2'b11);

    @(negedge clk) rst_n = 1'b0;
    disp_valid = '0; wb_valid = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset clears the pending count of register 30
    drive(t);
    check("R1 cleared by reset (bypass)", stall, 2'b00);
    check("R1 cleared by reset (no bypass)", stall_nb, 2'b00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule